// File: doc/BRIEF.md
# Serial Mode-Tagged Frame Receiver

This block takes a three-wire serial stream (select, shift clock, data) from a host controller and turns it into the stored state for a multiplexed fluorescent display. The host sends either a segment frame or a dimming frame. Each frame ends with a three-bit mode tag that says where the payload goes. When select drops, the block reads the tag from the last bits it received. It then writes the payload into one segment latch, into all three segment latches at once, or into the dimming latch.

The serial wires are sampled in the block's own clock domain and must already be synchronous to it. The shift clock is edge-detected internally. Both frame lengths travel through one shift path, and a bit counter that stops at its maximum decides whether the frame was long enough to commit. The latched segment words and the dimming value go straight to the display timing logic.

Top module: `vfd_frame_rx`

## Requirements
- R1: Bits are shifted in only on a rising edge of `sclk_i` while `cs_i` is high. Shift-clock edges while `cs_i` is low change no output and do not affect the next frame.
- R2: A segment frame is 35 bits: S1 first up to S32, then M0, M1, M2. Bit Sn lands in bit n-1 of the target grid's 32-bit field. Grid g (0-based) occupies `grid_seg_o[g*32 +: 32]`, and a 1 lights the segment.
- R3: A dimming frame is 13 bits: D1 first up to D10, then M0, M1, M2. D1 lands in `dim_o[0]` and D10 in `dim_o[9]`.
- R4: The tag M2 M1 M0 decodes as follows. 000 writes the segment payload to all three grids. 001, 010 and 011 write only grid 0, 1 or 2. 100 writes the dimming latch.
- R5: Tags 101, 110 and 111 leave every latch unchanged.
- R6: A frame with fewer than 13 bits is discarded. A frame with a segment tag and fewer than 35 bits is discarded. A dimming-tagged frame of 13 or more bits is accepted.
- R7: A frame longer than its nominal length is decoded from its final bits: the last three bits are the tag, and the payload is the 32 or 10 bits just before them.
- R8: After reset, all segment latches and the dimming latch read 0.
- R9: Latches change only on the falling edge of `cs_i`, and the new value appears one clock after `cs_i` is first sampled low. While `cs_i` stays high the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Frame select, high while a frame is shifted |
| sclk_i | input | 1 | Serial shift clock, sampled on its rising edge |
| sdata_i | input | 1 | Serial data |
| grid_seg_o | output | 96 | Three 32-bit segment latches, grid g at bits g*32 and up |
| dim_o | output | 10 | Dimming latch |

## Verification
The assertions assume that `cs_i`, `sclk_i` and `sdata_i` are synchronous to `clk_i`. They also assume that each shift-clock level lasts at least one clock, so that every rising edge is seen exactly once. The bench drives all three wires on the falling clock edge and holds each shift-clock level for two clocks. It leaves two clocks after each select transition before sampling. Random frames mix valid, reserved, short and over-long streams, and directed frames cover the tag boundaries and the exact 13- and 35-bit lengths.

// File: rtl/vfd_rx_pkg.sv
package vfd_rx_pkg;
  localparam int unsigned SEG_W     = 32;
  localparam int unsigned DIM_W     = 10;
  localparam int unsigned TAG_W     = 3;
  localparam int unsigned NUM_GRIDS = 3;

  typedef enum logic [TAG_W-1:0] {
    MODE_ALL = 3'd0,
    MODE_G1  = 3'd1,
    MODE_G2  = 3'd2,
    MODE_G3  = 3'd3,
    MODE_DIM = 3'd4
  } mode_e;
endpackage

// File: rtl/frame_shift.sv
module frame_shift #(
  parameter int unsigned SEG_W = vfd_rx_pkg::SEG_W,
  parameter int unsigned TAG_W = vfd_rx_pkg::TAG_W,
  localparam int unsigned SR_W  = SEG_W + TAG_W,
  localparam int unsigned CNT_W = $clog2(SR_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic [SR_W-1:0]  sr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             commit_o
);
  logic             cs_q, sclk_q, shift_en;
  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q;

  assign shift_en = cs_i & sclk_i & ~sclk_q;
  assign commit_o = cs_q & ~cs_i;
  assign sr_o     = sr_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
      sr_q   <= '0;
      cnt_q  <= '0;
    end else begin
      cs_q   <= cs_i;
      sclk_q <= sclk_i;
      if (shift_en) sr_q <= {sr_q[SR_W-2:0], sdata_i};
      if (!cs_i) cnt_q <= '0;
      else if (shift_en && cnt_q != CNT_W'(SR_W)) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(sr_q)); // R1
  AST_CNT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && cnt_q == CNT_W'(SR_W)) |=> (cnt_q == CNT_W'(SR_W) || !cs_i)); // R7
endmodule

// File: rtl/tag_decode.sv
module tag_decode #(
  parameter int unsigned SEG_W     = vfd_rx_pkg::SEG_W,
  parameter int unsigned DIM_W     = vfd_rx_pkg::DIM_W,
  parameter int unsigned TAG_W     = vfd_rx_pkg::TAG_W,
  parameter int unsigned NUM_GRIDS = vfd_rx_pkg::NUM_GRIDS,
  localparam int unsigned SR_W     = SEG_W + TAG_W,
  localparam int unsigned DFR_W    = DIM_W + TAG_W,
  localparam int unsigned CNT_W    = $clog2(SR_W + 1),
  localparam int unsigned DIM_CODE = NUM_GRIDS + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SR_W-1:0]      sr_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 commit_i,
  output logic [NUM_GRIDS-1:0] seg_we_o,
  output logic                 dim_we_o,
  output logic [SEG_W-1:0]     seg_data_o,
  output logic [DIM_W-1:0]     dim_data_o
);
  logic [TAG_W-1:0] tag;
  logic             seg_len_ok, dim_len_ok;

  // first-sent bit sits highest in the shift path
  always_comb begin
    for (int k = 0; k < TAG_W; k++) tag[k] = sr_i[TAG_W-1-k];
    for (int i = 0; i < SEG_W; i++) seg_data_o[i] = sr_i[SR_W-1-i];
    for (int i = 0; i < DIM_W; i++) dim_data_o[i] = sr_i[DFR_W-1-i];
  end

  assign seg_len_ok = cnt_i >= CNT_W'(SR_W);
  assign dim_len_ok = cnt_i >= CNT_W'(DFR_W);
  assign dim_we_o   = commit_i & dim_len_ok & (tag == TAG_W'(DIM_CODE));

  for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_we
    assign seg_we_o[g] = commit_i & seg_len_ok &
                         (tag == TAG_W'(0) || tag == TAG_W'(g + 1));
  end

  AST_DIM_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dim_we_o |-> seg_we_o == '0); // R4
  AST_WE_NEEDS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |-> (seg_we_o == '0 && !dim_we_o)); // R9
endmodule

// File: rtl/disp_latch.sv
module disp_latch #(
  parameter int unsigned SEG_W     = vfd_rx_pkg::SEG_W,
  parameter int unsigned DIM_W     = vfd_rx_pkg::DIM_W,
  parameter int unsigned NUM_GRIDS = vfd_rx_pkg::NUM_GRIDS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_GRIDS-1:0]       seg_we_i,
  input  logic                       dim_we_i,
  input  logic [SEG_W-1:0]           seg_data_i,
  input  logic [DIM_W-1:0]           dim_data_i,
  output logic [NUM_GRIDS*SEG_W-1:0] grid_seg_o,
  output logic [DIM_W-1:0]           dim_o
);
  for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid
    logic [SEG_W-1:0] seg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          seg_q <= '0;
      else if (seg_we_i[g]) seg_q <= seg_data_i;
    end
    assign grid_seg_o[g*SEG_W +: SEG_W] = seg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dim_o <= '0;
    else if (dim_we_i) dim_o <= dim_data_i;
  end
endmodule

// File: rtl/vfd_frame_rx.sv
module vfd_frame_rx #(
  parameter int unsigned SEG_W     = vfd_rx_pkg::SEG_W,
  parameter int unsigned DIM_W     = vfd_rx_pkg::DIM_W,
  parameter int unsigned TAG_W     = vfd_rx_pkg::TAG_W,
  parameter int unsigned NUM_GRIDS = vfd_rx_pkg::NUM_GRIDS,
  localparam int unsigned SR_W     = SEG_W + TAG_W,
  localparam int unsigned CNT_W    = $clog2(SR_W + 1),
  localparam int unsigned OUT_W    = NUM_GRIDS * SEG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic [OUT_W-1:0] grid_seg_o,
  output logic [DIM_W-1:0] dim_o
);
  logic [SR_W-1:0]      sr;
  logic [CNT_W-1:0]     cnt;
  logic                 commit, dim_we;
  logic [NUM_GRIDS-1:0] seg_we;
  logic [SEG_W-1:0]     seg_data;
  logic [DIM_W-1:0]     dim_data;

  frame_shift #(.SEG_W(SEG_W), .TAG_W(TAG_W)) i_shift (
    .clk_i, .rst_ni, .cs_i, .sclk_i, .sdata_i,
    .sr_o(sr), .cnt_o(cnt), .commit_o(commit)
  );

  tag_decode #(.SEG_W(SEG_W), .DIM_W(DIM_W), .TAG_W(TAG_W), .NUM_GRIDS(NUM_GRIDS)) i_dec (
    .clk_i, .rst_ni, .sr_i(sr), .cnt_i(cnt), .commit_i(commit),
    .seg_we_o(seg_we), .dim_we_o(dim_we), .seg_data_o(seg_data), .dim_data_o(dim_data)
  );

  disp_latch #(.SEG_W(SEG_W), .DIM_W(DIM_W), .NUM_GRIDS(NUM_GRIDS)) i_latch (
    .clk_i, .rst_ni, .seg_we_i(seg_we), .dim_we_i(dim_we),
    .seg_data_i(seg_data), .dim_data_i(dim_data),
    .grid_seg_o, .dim_o
  );

  AST_HOLD_UNTIL_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> ($stable(grid_seg_o) && $stable(dim_o))); // R9
  AST_RESERVED_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && sr[0] && (sr[1] || sr[2])) |=> ($stable(grid_seg_o) && $stable(dim_o))); // R5
  AST_SHORT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && cnt < CNT_W'(DIM_W + TAG_W)) |=> ($stable(grid_seg_o) && $stable(dim_o))); // R6
endmodule

// File: tb/test_vfd_frame_rx.sv
module test_vfd_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [95:0] grid_seg;
  logic [9:0]  dim;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_g [3];
  logic [9:0]  exp_d;

  vfd_frame_rx i_vfd_frame_rx (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .sdata_i(sdata),
    .grid_seg_o(grid_seg), .dim_o(dim)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int g = 0; g < 3; g++) chk(req, grid_seg[g*32 +: 32], exp_g[g]);
    chk(req, {22'd0, dim}, {22'd0, exp_d});
  endtask

  task automatic send_bit(logic b);
    sdata = b; tick();
    sclk = 1'b1; tick(2);
    sclk = 1'b0; tick();
  endtask

  function automatic logic [63:0] seg_frame(logic [31:0] seg, logic [2:0] mode);
    logic [63:0] r = '0;
    for (int i = 0; i < 32; i++) r[34-i] = seg[i];
    r[2] = mode[0]; r[1] = mode[1]; r[0] = mode[2];
    return r;
  endfunction

  function automatic logic [63:0] dim_frame(logic [9:0] d, logic [2:0] mode);
    logic [63:0] r = '0;
    for (int i = 0; i < 10; i++) r[12-i] = d[i];
    r[2] = mode[0]; r[1] = mode[1]; r[0] = mode[2];
    return r;
  endfunction

  // expected effect of a stream (stream[n-1] sent first)
  function automatic void model(logic [63:0] s, int n);
    logic [2:0] tag;
    logic [31:0] seg;
    if (n < 13) return;
    tag = {s[0], s[1], s[2]};
    if (tag == 3'd4) begin
      for (int i = 0; i < 10; i++) exp_d[i] = s[12-i];
    end else if (tag < 3'd4 && n >= 35) begin
      for (int i = 0; i < 32; i++) seg[i] = s[34-i];
      for (int g = 0; g < 3; g++)
        if (tag == 3'd0 || tag == 3'(g + 1)) exp_g[g] = seg;
    end
  endfunction

  task automatic frame(string req, logic [63:0] s, int n, bit hold_chk = 0);
    cs = 1'b1; tick(2);
    for (int i = n - 1; i >= 0; i--) send_bit(s[i]);
    tick(2);
    if (hold_chk) chk_all("R9 hold while select high");
    cs = 1'b0; tick(2);
    model(s, n);
    chk_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int g = 0; g < 3; g++) exp_g[g] = '0;
    exp_d = '0;
    tick(3);
    chk_all("R8 reset state");
    rst_n = 1'b1; tick(2);
    chk_all("R8 after release");

    frame("R4 R2 broadcast", seg_frame(32'hA5A5_0F01, 3'd0), 35);
    frame("R2 S1 maps to bit 0", seg_frame(32'h0000_0001, 3'd1), 35);
    frame("R2 S32 maps to bit 31", seg_frame(32'h8000_0000, 3'd3), 35);
    frame("R4 single grid", seg_frame(32'h1234_5678, 3'd2), 35, 1);
    frame("R3 dim D1 and D10", dim_frame(10'h201, 3'd4), 13);
    frame("R3 dim low bits", dim_frame(10'h003, 3'd4), 13, 1);
    frame("R5 tag 5 ignored", seg_frame(32'hFFFF_FFFF, 3'd5), 35);
    frame("R5 tag 6 ignored", dim_frame(10'h3FF, 3'd6), 13);
    frame("R5 tag 7 ignored", seg_frame(32'hDEAD_BEEF, 3'd7), 35);
    frame("R6 12-bit dim dropped", dim_frame(10'h155, 3'd4) >> 1, 12);
    frame("R6 34-bit seg dropped", seg_frame(32'hCAFE_F00D, 3'd0), 34);
    frame("R6 20-bit dim accepted", dim_frame(10'h2AA, 3'd4) | (64'hF << 13), 20);
    frame("R7 50-bit seg frame", seg_frame(32'h0BAD_C0DE, 3'd0) | (64'h5A5A << 35), 50);
    frame("R7 64-bit dim frame", dim_frame(10'h111, 3'd4) | (64'hFFFF_FFFF_FFFF_E000), 64);

    // shift clocks with select low
    for (int i = 0; i < 20; i++) send_bit(i[0]);
    tick(2);
    chk_all("R1 clocks with select low");
    frame("R1 next frame unaffected", dim_frame(10'h0F0, 3'd4), 13);

    for (int it = 0; it < 60; it++) begin
      logic [63:0] s;
      int n;
      int pick;
      s = {$urandom(), $urandom()};
      pick = int'($urandom_range(0, 3));
      n = (pick == 0) ? 13 : (pick == 1) ? 35 : int'($urandom_range(5, 64));
      if ($urandom_range(0, 9) < 7) begin
        logic [2:0] m;
        m = 3'($urandom_range(0, 4));
        s[2] = m[0]; s[1] = m[1]; s[0] = m[2];
      end
      frame("R7 random stream", s, n);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule